// File: doc/BRIEF.md
# Read Completion Reorder Buffer

This block sits between a DMA engine that issues memory read requests and the consumer of the returned data. Each accepted request is given a tag from a circular pool in issue order, together with a beat count derived from its byte length. Split completions for different requests may come back in any order and interleaved beat by beat. Completions for one request always arrive in ascending address order, so each tag needs only an append counter into its own fixed-size slot.

The output side is a valid/ready stream that always presents the oldest outstanding request first. It starts streaming a request's beats as soon as they land, marks the final beat of each request, and frees the tag once that beat is taken. Requests that are empty or larger than one slot are refused at issue. Completions that cannot belong to a live request are dropped, and a sticky error flag records them.

Top module: `cplReorderBuf`

## Requirements
- R1: After reset, reqReady is 1, reqTag is 0, outValid is 0 and errFlag is 0.
- R2: Accepted requests receive tags 0, 1, ..., NUM_TAGS-1 in issue order, then wrap to 0. reqTag shows the tag granted in the handshake cycle. reqReady is 0 while all NUM_TAGS tags are outstanding.
- R3: A request whose byte count is 0 or exceeds MAX_BEATS*DATA_W/8 raises reqReject in its handshake cycle and consumes no tag.
- R4: A request of B bytes produces exactly ceil(B/(DATA_W/8)) output beats, and outLast is 1 on the final beat only.
- R5: Output data follows request issue order regardless of completion order or interleaving. Within one request, the beats keep their arrival order.
- R6: A completion beat whose tag is not outstanding, or that exceeds the request's beat count, is dropped and sets errFlag. errFlag then stays 1 until reset.
- R7: If the final expected beat of a request arrives with cplLast at 0, errFlag is set. The beat is still stored and delivered.
- R8: While outValid is 1 and outReady is 0, outValid and outData hold. Completion beats that arrive during the stall are kept.
- R9: When the final beat of the oldest request is taken, its tag is freed. If every tag was in use, reqReady rises in the cycle after that transfer.
- R10: A beat of the oldest request is offered on the output in the cycle after it arrives, before the rest of that request has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request offered |
| reqBytes | input | LEN_W | Requested byte count |
| reqReady | output | 1 | A free tag is available |
| reqTag | output | TAG_W | Tag granted to the current request |
| reqReject | output | 1 | Current request refused for its size |
| cplValid | input | 1 | Completion beat present |
| cplTag | input | TAG_W | Tag of the completion beat |
| cplData | input | DATA_W | Completion data beat |
| cplLast | input | 1 | Beat ends its completion |
| outValid | output | 1 | In-order beat available |
| outReady | input | 1 | Consumer accepts the beat |
| outData | output | DATA_W | In-order data beat |
| outLast | output | 1 | Final beat of the request |
| errFlag | output | 1 | Sticky completion error |

## Verification
The assertions assume that the request size bounds the beats the completer returns. They also assume that a tag's completions keep address order, and that the consumer stays within the valid/ready handshake. The directed bench drives completions only for tags it holds and keeps per-request beat order when it shuffles across requests. It breaks these assumptions deliberately only in the error scenarios, which check errFlag and the output stream instead of relying on the stall and ordering properties.

// File: rtl/cplReorderPkg.sv
package cplReorderPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
  } dpStrobeT;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/cplReorderCtrl.sv
module cplReorderCtrl
  import cplReorderPkg::*;
#(
  parameter int NUM_TAGS   = 8,
  parameter int MAX_BEATS  = 4,
  parameter int BEAT_BYTES = 4,
  parameter int LEN_W      = 6,
  parameter int TAG_W      = $clog2(NUM_TAGS),
  parameter int IDX_W      = $clog2(MAX_BEATS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [LEN_W-1:0]       reqBytes,
  output logic                   reqReady,
  output logic [TAG_W-1:0]       reqTag,
  output logic                   reqReject,
  input  logic                   cplValid,
  input  logic [TAG_W-1:0]       cplTag,
  input  logic                   cplLast,
  output logic                   outValid,
  input  logic                   outReady,
  output logic                   outLast,
  output logic                   errFlag,
  output dpStrobeT               strobe,
  output logic [TAG_W+IDX_W-1:0] wrAddr,
  output logic [TAG_W+IDX_W-1:0] rdAddr
);

  localparam int CNT_W     = $clog2(MAX_BEATS + 1);
  localparam int MAX_BYTES = MAX_BEATS * BEAT_BYTES;

  logic [NUM_TAGS-1:0] busy;
  logic [CNT_W-1:0]    expCnt [NUM_TAGS];
  logic [CNT_W-1:0]    rcvCnt [NUM_TAGS];
  logic [TAG_W-1:0]    wrPtr;
  logic [TAG_W-1:0]    rdPtr;
  logic [CNT_W-1:0]    dlvCnt;
  logic                errQ;

  logic             sizeOk, reqFire, alloc, cplHit, lastMiss, outFire, doneOldest;
  logic [CNT_W-1:0] reqBeats, hitRcv, hitExp;

  always_comb begin
    sizeOk     = (reqBytes != '0) && (reqBytes <= LEN_W'(MAX_BYTES));
    reqBeats   = CNT_W'(ceilDiv(int'(reqBytes), BEAT_BYTES));
    reqReady   = !busy[wrPtr];
    reqFire    = reqValid && reqReady;
    alloc      = reqFire && sizeOk;
    reqReject  = reqFire && !sizeOk;
    reqTag     = wrPtr;

    hitRcv     = rcvCnt[cplTag];
    hitExp     = expCnt[cplTag];
    cplHit     = cplValid && busy[cplTag] && (hitRcv < hitExp);
    lastMiss   = cplHit && ((hitRcv + CNT_W'(1)) == hitExp) && !cplLast;

    outValid   = busy[rdPtr] && (rcvCnt[rdPtr] > dlvCnt);
    outLast    = (dlvCnt + CNT_W'(1)) == expCnt[rdPtr];
    outFire    = outValid && outReady;
    doneOldest = outFire && outLast;

    strobe.wrEn = cplHit;
    wrAddr      = {cplTag, hitRcv[IDX_W-1:0]};
    rdAddr      = {rdPtr, dlvCnt[IDX_W-1:0]};
    errFlag     = errQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      dlvCnt <= '0;
      errQ   <= 1'b0;
      for (int i = 0; i < NUM_TAGS; i++) begin
        expCnt[i] <= '0;
        rcvCnt[i] <= '0;
      end
    end else begin
      if (alloc) begin
        busy[wrPtr]   <= 1'b1;
        expCnt[wrPtr] <= reqBeats;
        rcvCnt[wrPtr] <= '0;
        wrPtr         <= wrPtr + TAG_W'(1);
      end
      if (cplHit) begin
        rcvCnt[cplTag] <= hitRcv + CNT_W'(1);
      end
      if ((cplValid && !cplHit) || lastMiss) begin
        errQ <= 1'b1;
      end
      if (outFire) begin
        if (outLast) begin
          busy[rdPtr] <= 1'b0;
          rdPtr       <= rdPtr + TAG_W'(1);
          dlvCnt      <= '0;
        end else begin
          dlvCnt <= dlvCnt + CNT_W'(1);
        end
      end
    end
  end

  AST_REQ_ALLOCATES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqReject) |=> busy[$past(wrPtr)]); // R2

  AST_REJECT_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |=> $stable(wrPtr)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R6

  AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (rdPtr == $past(rdPtr) + TAG_W'(1))); // R5

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(rdAddr))); // R8

endmodule

// File: rtl/cplReorderData.sv
module cplReorderData
  import cplReorderPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] slotMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      slotMem[wrAddr] <= wrData;
    end
  end

  assign rdData = slotMem[rdAddr];

endmodule

// File: rtl/cplReorderBuf.sv
module cplReorderBuf
  import cplReorderPkg::*;
#(
  parameter int NUM_TAGS  = 8,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int TAG_W     = $clog2(NUM_TAGS),
  parameter int LEN_W     = $clog2(MAX_BEATS * (DATA_W / 8)) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LEN_W-1:0]  reqBytes,
  output logic              reqReady,
  output logic [TAG_W-1:0]  reqTag,
  output logic              reqReject,
  input  logic              cplValid,
  input  logic [TAG_W-1:0]  cplTag,
  input  logic [DATA_W-1:0] cplData,
  input  logic              cplLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              errFlag
);

  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int IDX_W      = $clog2(MAX_BEATS);
  localparam int DEPTH      = NUM_TAGS * MAX_BEATS;
  localparam int ADDR_W     = TAG_W + IDX_W;

  dpStrobeT          strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  cplReorderCtrl #(
    .NUM_TAGS  (NUM_TAGS),
    .MAX_BEATS (MAX_BEATS),
    .BEAT_BYTES(BEAT_BYTES),
    .LEN_W     (LEN_W),
    .TAG_W     (TAG_W),
    .IDX_W     (IDX_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBytes (reqBytes),
    .reqReady (reqReady),
    .reqTag   (reqTag),
    .reqReject(reqReject),
    .cplValid (cplValid),
    .cplTag   (cplTag),
    .cplLast  (cplLast),
    .outValid (outValid),
    .outReady (outReady),
    .outLast  (outLast),
    .errFlag  (errFlag),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr)
  );

  cplReorderData #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) uData (
    .clk   (clk),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .wrData(cplData),
    .rdAddr(rdAddr),
    .rdData(outData)
  );

  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData)); // R8

  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |-> !reqReject); // R2

endmodule

// File: tb/tb_cplReorderBuf.sv
module tb_cplReorderBuf;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [5:0]  reqBytes;
  logic        reqReady;
  logic [2:0]  reqTag;
  logic        reqReject;
  logic        cplValid;
  logic [2:0]  cplTag;
  logic [31:0] cplData;
  logic        cplLast;
  logic        outValid;
  logic        outReady;
  logic [31:0] outData;
  logic        outLast;
  logic        errFlag;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] gotData [256];
  logic        gotLast [256];
  int gotN = 0;
  int nextTag = 0;

  always #5 clk = ~clk;

  cplReorderBuf dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBytes(reqBytes),
    .reqReady(reqReady), .reqTag(reqTag), .reqReject(reqReject),
    .cplValid(cplValid), .cplTag(cplTag), .cplData(cplData), .cplLast(cplLast),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .errFlag(errFlag)
  );

  // capture transfers 1 ns before the edge that completes them
  always begin
    @(negedge clk);
    #4;
    if (rstN && outValid && outReady && gotN < 256) begin
      gotData[gotN] = outData;
      gotLast[gotN] = outLast;
      gotN++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 0; reqBytes = 0; cplValid = 0; cplTag = 0;
    cplData = 0; cplLast = 0; outReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    gotN = 0;
    nextTag = 0;
  endtask

  task automatic issueReq(input int bytes, output logic [2:0] tag, output logic rej, output logic rdy);
    @(negedge clk);
    reqValid = 1'b1;
    reqBytes = 6'(bytes);
    #1;
    tag = reqTag; rej = reqReject; rdy = reqReady;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
  endtask

  task automatic sendBeat(input logic [2:0] tag, input logic [31:0] data, input logic last);
    @(negedge clk);
    cplValid = 1'b1; cplTag = tag; cplData = data; cplLast = last;
    @(posedge clk);
    #1;
    cplValid = 1'b0; cplLast = 1'b0;
  endtask

  task automatic waitOut(input int n);
    for (int i = 0; i < 400; i++) begin
      if (gotN >= n) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk); #1;
    chk(reqReady == 1'b1, "R1 reqReady", 32'(reqReady), 1);
    chk(reqTag == 3'd0, "R1 reqTag", 32'(reqTag), 0);
    chk(outValid == 1'b0, "R1 outValid", 32'(outValid), 0);
    chk(errFlag == 1'b0, "R1 errFlag", 32'(errFlag), 0);
  endtask

  // one 5-byte request: two beats, last on the second
  task automatic testSingle();
    logic [2:0] t; logic rj, rd;
    doReset();
    outReady = 1'b1;
    issueReq(5, t, rj, rd);
    chk(t == 3'd0 && !rj, "R2 first tag", 32'(t), 0);
    nextTag = 1;
    sendBeat(t, 32'hA0, 1'b0);
    sendBeat(t, 32'hA1, 1'b1);
    waitOut(2);
    chk(gotN == 2, "R4 beat count", 32'(gotN), 2);
    chk(gotData[0] == 32'hA0 && !gotLast[0], "R4 beat0", gotData[0], 32'hA0);
    chk(gotData[1] == 32'hA1 && gotLast[1], "R4 beat1 last", 32'(gotLast[1]), 1);
  endtask

  // fill all tags, return completions shuffled and interleaved
  task automatic testShuffle(input int seqBase);
    int beats [8];
    logic [2:0] tags [8];
    int sent [8];
    int total, left, k, r;
    logic rj, rd, lastF;
    gotN = 0;
    total = 0;
    for (int i = 0; i < 8; i++) begin
      int bytes;
      bytes = 1 + int'($urandom % 16);
      beats[i] = (bytes + 3) / 4;
      total += beats[i];
      issueReq(bytes, tags[i], rj, rd);
      chk(rd && !rj, "R2 accepted", 32'(rd), 1);
      chk(int'(tags[i]) == nextTag, "R2 tag order", 32'(tags[i]), 32'(nextTag));
      nextTag = (nextTag + 1) % 8;
      sent[i] = 0;
    end
    @(negedge clk); #1;
    chk(reqReady == 1'b0, "R2 full not ready", 32'(reqReady), 0);
    left = total;
    while (left > 0) begin
      r = int'($urandom % 8);
      if (sent[r] < beats[r]) begin
        lastF = (sent[r] + 1 == beats[r]) || ($urandom % 4 == 0);
        outReady = 1'($urandom % 2);
        sendBeat(tags[r], {16'(seqBase + r), 16'(sent[r])}, lastF);
        sent[r]++;
        left--;
      end
    end
    outReady = 1'b1;
    waitOut(total);
    chk(gotN == total, "R5 total beats", 32'(gotN), 32'(total));
    k = 0;
    for (int i = 0; i < 8; i++) begin
      for (int b = 0; b < beats[i]; b++) begin
        logic [31:0] e;
        e = {16'(seqBase + i), 16'(b)};
        chk(gotData[k] == e, "R5 order", gotData[k], e);
        chk(gotLast[k] == (b == beats[i] - 1), "R4 last marker", 32'(gotLast[k]), 32'(b == beats[i] - 1));
        k++;
      end
    end
    chk(errFlag == 1'b0, "R6 no error", 32'(errFlag), 0);
    chk(reqReady == 1'b1, "R9 ready after drain", 32'(reqReady), 1);
  endtask

  task automatic testReject();
    logic [2:0] t; logic rj, rd;
    doReset();
    issueReq(0, t, rj, rd);
    chk(rj == 1'b1, "R3 zero bytes", 32'(rj), 1);
    issueReq(17, t, rj, rd);
    chk(rj == 1'b1, "R3 oversize", 32'(rj), 1);
    issueReq(16, t, rj, rd);
    chk(rj == 1'b0 && t == 3'd0, "R3 tag unused", 32'(t), 0);
    @(negedge clk); #1;
    chk(outValid == 1'b0, "R3 no output", 32'(outValid), 0);
  endtask

  task automatic testErrors();
    logic [2:0] t; logic rj, rd;
    doReset();
    sendBeat(3'd3, 32'hBAD, 1'b1);
    @(negedge clk); #1;
    chk(errFlag == 1'b1, "R6 unknown tag", 32'(errFlag), 1);
    chk(outValid == 1'b0, "R6 dropped", 32'(outValid), 0);
    repeat (4) @(negedge clk);
    chk(errFlag == 1'b1, "R6 sticky", 32'(errFlag), 1);

    doReset();
    issueReq(4, t, rj, rd);
    sendBeat(t, 32'hC0, 1'b1);
    @(negedge clk); #1;
    chk(errFlag == 1'b0, "R6 legal beat", 32'(errFlag), 0);
    sendBeat(t, 32'hC1, 1'b1);
    @(negedge clk); #1;
    chk(errFlag == 1'b1, "R6 excess beat", 32'(errFlag), 1);
    outReady = 1'b1;
    waitOut(1);
    chk(gotN == 1 && gotData[0] == 32'hC0, "R6 excess dropped", gotData[0], 32'hC0);

    doReset();
    issueReq(8, t, rj, rd);
    sendBeat(t, 32'hD0, 1'b0);
    @(negedge clk); #1;
    chk(errFlag == 1'b0, "R7 mid beat", 32'(errFlag), 0);
    sendBeat(t, 32'hD1, 1'b0);
    @(negedge clk); #1;
    chk(errFlag == 1'b1, "R7 missing end flag", 32'(errFlag), 1);
    outReady = 1'b1;
    waitOut(2);
    chk(gotN == 2 && gotData[1] == 32'hD1 && gotLast[1], "R7 beat kept", gotData[1], 32'hD1);
  endtask

  task automatic testFreeTag();
    logic [2:0] t0, t; logic rj, rd;
    doReset();
    for (int i = 0; i < 8; i++) begin
      issueReq(4, t, rj, rd);
      if (i == 0) t0 = t;
    end
    @(negedge clk); #1;
    chk(reqReady == 1'b0, "R9 full", 32'(reqReady), 0);
    outReady = 1'b1;
    sendBeat(t0, 32'hE0, 1'b1);
    @(negedge clk); #1;
    chk(reqReady == 1'b0, "R9 not yet freed", 32'(reqReady), 0);
    chk(outValid && outLast, "R9 last offered", 32'(outValid), 1);
    @(negedge clk); #1;
    chk(reqReady == 1'b1, "R9 freed", 32'(reqReady), 1);
    chk(gotN == 1 && gotData[0] == 32'hE0, "R9 data", gotData[0], 32'hE0);
  endtask

  task automatic testStream();
    logic [2:0] t; logic rj, rd;
    logic [31:0] held;
    doReset();
    issueReq(16, t, rj, rd);
    sendBeat(t, 32'hF0, 1'b0);
    @(negedge clk); #1;
    chk(outValid == 1'b1, "R10 early valid", 32'(outValid), 1);
    chk(outLast == 1'b0, "R10 not last", 32'(outLast), 0);
    chk(outData == 32'hF0, "R10 data", outData, 32'hF0);
    held = outData;
    sendBeat(t, 32'hF1, 1'b0);
    sendBeat(t, 32'hF2, 1'b0);
    @(negedge clk); #1;
    chk(outValid && outData == held, "R8 stall holds", outData, held);
    sendBeat(t, 32'hF3, 1'b1);
    outReady = 1'b1;
    waitOut(4);
    chk(gotN == 4, "R8 no beat lost", 32'(gotN), 4);
    for (int i = 0; i < 4; i++) begin
      chk(gotData[i] == 32'hF0 + 32'(i), "R8 order after stall", gotData[i], 32'hF0 + 32'(i));
    end
    chk(gotLast[3] && !gotLast[2], "R4 last on fourth", 32'(gotLast[3]), 1);
  endtask

  initial begin
    testReset();
    testSingle();
    testShuffle(16);
    testShuffle(32);
    testReject();
    testErrors();
    testFreeTag();
    testStream();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule